// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C master from the system clock. A prescaler divides the system clock into module-clock ticks. A phase timer counts those ticks to form the low and high halves of SCL. The divider settings are sampled only while the block is held idle with `enable_i` low, so software programs the dividers first and then releases the block.

Each half of the SCL period lasts its programmed count plus a fixed offset added in hardware. The offset depends on the prescale value: 7 when the prescale is 0, 6 when it is 1, and 5 when it is 2 or more. A mode input pins the offset at 6 whatever the prescale. Two one-cycle strobes mark the falling and rising SCL edges, and the surrounding controller uses them as bit-timing ticks. The block can optionally extend the high half while another device holds the line low (clock stretching).

Top module: `i2c_scl_gen`

## Requirements
- R1: The prescaler emits one module tick every PSC+1 system cycles. PSC is `psc_i` as an unsigned 16-bit value.
- R2: The high half of SCL lasts (CLKH+d)·(PSC+1) system cycles and the low half lasts (CLKL+d)·(PSC+1). After enable the block starts with a high half, so the first fall comes (CLKH+d)·(PSC+1) cycles after the first enabled clock edge minus one.
- R3: With `offset6_mode_i` at 0, the offset d is 7 for PSC=0, 6 for PSC=1 and 5 for PSC≥2.
- R4: With `offset6_mode_i` at 1, d is 6 for every PSC value.
- R5: A high count of 0 is legal and gives a high half of d ticks.
- R6: PSC, CLKL, CLKH and the offset mode are captured only on clock edges where `enable_i` is low. Changes on these inputs while enabled do not alter the SCL timing.
- R7: The first clock edge with `enable_i` low drives `scl_o` high and restarts both counters, with no strobe. While disabled, SCL stays high and no strobe fires. On re-enable the timing starts again from the beginning of a high half.
- R8: `scl_fall_o` and `scl_rise_o` are each one system cycle wide. Each is asserted in exactly the cycle in which `scl_o` shows its new level after a timed edge. The two are never asserted together.
- R9: With `stretch_en_i` at 1, each module tick during the high half in which `scl_i` is sampled low is not counted, so the high half grows by one tick per such tick. With `stretch_en_i` at 0, `scl_i` has no effect.
- R10: During reset `scl_o` is high and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the generator when high; holds it idle and loads the dividers when low |
| psc_i | input | 16 | Prescale value; module tick every psc_i+1 cycles |
| clkl_i | input | 16 | Low-half tick count before the offset |
| clkh_i | input | 16 | High-half tick count before the offset |
| offset6_mode_i | input | 1 | Forces the phase offset to 6 |
| stretch_en_i | input | 1 | Enables clock stretching during the high half |
| scl_i | input | 1 | Sampled level of the SCL line |
| scl_o | output | 1 | Generated SCL level (1 = released high) |
| scl_rise_o | output | 1 | One-cycle strobe with the SCL rising edge |
| scl_fall_o | output | 1 | One-cycle strobe with the SCL falling edge |

## Verification
SCL and its strobe are updated by the same register, so every result is due a whole number of system cycles after the enable edge. The first falling strobe appears (CLKH+d)·(PSC+1) cycles after enable is driven. Each later strobe appears one phase length after the strobe before it, and a stretched high half is longer by exactly the number of held cycles when PSC is 0. The bench sets a cycle mark when it raises enable and at every strobe. It samples on the falling clock edge and compares each measured gap and edge kind against the queued expectation. A disable is checked one cycle after it is driven, because SCL returns high on the next clock edge.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_PSC0  = 3'd7;
  localparam logic [OFS_W-1:0] OFS_PSC1  = 3'd6;
  localparam logic [OFS_W-1:0] OFS_PSCN  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_FIXED = 3'd6;

  function automatic logic [OFS_W-1:0] phase_offset(input logic fixed6,
                                                    input logic psc_is0,
                                                    input logic psc_is1);
    if (fixed6)       return OFS_FIXED;
    else if (psc_is0) return OFS_PSC0;
    else if (psc_is1) return OFS_PSC1;
    else              return OFS_PSCN;
  endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] clkl_i,
  input  logic [CNT_W-1:0] clkh_i,
  input  logic             offset6_mode_i,
  output logic [CNT_W-1:0] psc_o,
  output logic [CNT_W:0]   low_len_o,
  output logic [CNT_W:0]   high_len_o
);

  localparam int LEN_W = CNT_W + 1;

  logic [OFS_W-1:0] ofs;
  logic [LEN_W-1:0] low_len_d, high_len_d;

  assign ofs = phase_offset(offset6_mode_i, psc_i == '0,
                            psc_i == CNT_W'(1));
  // offset folded in here, keeps the phase compare a single equality
  assign low_len_d  = {1'b0, clkl_i} + LEN_W'(ofs);
  assign high_len_d = {1'b0, clkh_i} + LEN_W'(ofs);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_o      <= '0;
      low_len_o  <= LEN_W'(OFS_PSC0);
      high_len_o <= LEN_W'(OFS_PSC0);
    end else if (!enable_i) begin
      psc_o      <= psc_i;
      low_len_o  <= low_len_d;
      high_len_o <= high_len_d;
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = enable_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!enable_i) cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_gen_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  input  logic             stretch_en_i,
  input  logic             scl_i,
  output logic             scl_o,
  output logic             rise_o,
  output logic             fall_o
);

  scl_phase_e       phase_q;
  logic [LEN_W-1:0] pcnt_q;
  logic [LEN_W-1:0] cur_len;
  logic             hold, last;

  assign cur_len = (phase_q == PH_HIGH) ? high_len_i : low_len_i;
  assign last    = (pcnt_q == cur_len - 1'b1);
  // line held low by another device during our high half
  assign hold    = stretch_en_i && (phase_q == PH_HIGH) && !scl_i;
  assign scl_o   = (phase_q == PH_HIGH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HIGH;
      pcnt_q  <= '0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else if (!enable_i) begin
      phase_q <= PH_HIGH;
      pcnt_q  <= '0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (tick_i && !hold) begin
        if (last) begin
          pcnt_q <= '0;
          if (phase_q == PH_HIGH) begin
            phase_q <= PH_LOW;
            fall_o  <= 1'b1;
          end else begin
            phase_q <= PH_HIGH;
            rise_o  <= 1'b1;
          end
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] clkl_i,
  input  logic [CNT_W-1:0] clkh_i,
  input  logic             offset6_mode_i,
  input  logic             stretch_en_i,
  input  logic             scl_i,
  output logic             scl_o,
  output logic             scl_rise_o,
  output logic             scl_fall_o
);

  localparam int LEN_W = CNT_W + 1;

  logic [CNT_W-1:0] psc_q;
  logic [LEN_W-1:0] low_len, high_len;
  logic             tick;

  scl_cfg_hold #(.CNT_W(CNT_W)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .psc_i         (psc_i),
    .clkl_i        (clkl_i),
    .clkh_i        (clkh_i),
    .offset6_mode_i(offset6_mode_i),
    .psc_o         (psc_q),
    .low_len_o     (low_len),
    .high_len_o    (high_len)
  );

  scl_prescaler #(.CNT_W(CNT_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .div_i   (psc_q),
    .tick_o  (tick)
  );

  scl_phase_timer #(.LEN_W(LEN_W)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .tick_i      (tick),
    .low_len_i   (low_len),
    .high_len_i  (high_len),
    .stretch_en_i(stretch_en_i),
    .scl_i       (scl_i),
    .scl_o       (scl_o),
    .rise_o      (scl_rise_o),
    .fall_o      (scl_fall_o)
  );

endmodule

// File: rtl/scl_gen_checker.sv
module scl_gen_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic stretch_en_i,
  input logic scl_i,
  input logic scl_o,
  input logic scl_rise_o,
  input logic scl_fall_o
);

  p_no_dual_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_rise_o && scl_fall_o));

  p_rise_marks_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> scl_o && !$past(scl_o));

  p_fall_marks_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |-> !scl_o && $past(scl_o));

  p_fall_flagged_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> scl_fall_o);

  p_rise_flagged_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_o) && $past(enable_i) |-> scl_rise_o);

  p_idle_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> scl_o && !scl_rise_o && !scl_fall_o);

  p_stretch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && stretch_en_i && scl_o && !scl_i |=> scl_o && !scl_fall_o);

endmodule

bind i2c_scl_gen scl_gen_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .stretch_en_i(stretch_en_i),
  .scl_i       (scl_i),
  .scl_o       (scl_o),
  .scl_rise_o  (scl_rise_o),
  .scl_fall_o  (scl_fall_o)
);

// File: tb/i2c_scl_gen_tb.sv
`timescale 1ns/1ps
module i2c_scl_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] psc = '0, clkl = '0, clkh = '0;
  logic        off6 = 1'b0, str_en = 1'b0, hold = 1'b0;
  logic        scl_i, scl_o, scl_rise, scl_fall;

  always #2.5 clk = ~clk;

  assign scl_i = scl_o & ~hold;

  i2c_scl_gen u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .enable_i      (enable),
    .psc_i         (psc),
    .clkl_i        (clkl),
    .clkh_i        (clkh),
    .offset6_mode_i(off6),
    .stretch_en_i  (str_en),
    .scl_i         (scl_i),
    .scl_o         (scl_o),
    .scl_rise_o    (scl_rise),
    .scl_fall_o    (scl_fall)
  );

  typedef struct {
    logic  rise;
    int    gap;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   cyc = 0, mark = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per observed strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (scl_rise || scl_fall)) begin
        automatic int gap = cyc - mark;
        check(scl_o == scl_rise, "R8", "scl level at strobe", scl_o, scl_rise);
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected strobe gap", gap, -1);
        end else begin
          automatic exp_t e = q.pop_front();
          check(e.rise == scl_rise, e.req, "edge kind", scl_rise, e.rise);
          check(gap == e.gap, e.req, "gap cycles", gap, e.gap);
        end
        mark = cyc;
      end
    end
  end

  task automatic setup(input int p, input int l, input int h,
                       input bit f, input bit s);
    @(negedge clk);
    enable = 1'b0;
    psc = 16'(p); clkl = 16'(l); clkh = 16'(h);
    off6 = f; str_en = s;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(input bit r, input int g, input string req);
    exp_t e;
    e.rise = r; e.gap = g; e.req = req;
    q.push_back(e);
  endtask

  task automatic go();
    enable = 1'b1;
    mark = cyc;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(scl_o == 1'b1, "R10", "scl in reset", scl_o, 1);
    check(scl_rise == 1'b0 && scl_fall == 1'b0, "R10", "strobes in reset",
          scl_rise | scl_fall, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(scl_o == 1'b1, "R7", "idle while disabled", scl_o, 1);

    // R2 R3: psc 0, d 7
    setup(0, 3, 2, 1'b0, 1'b0);
    push(1'b0, 9, "R2"); push(1'b1, 10, "R2");
    push(1'b0, 9, "R3"); push(1'b1, 10, "R3");
    go(); drain();

    // R3 R5: psc 1, d 6, high count 0
    setup(1, 4, 0, 1'b0, 1'b0);
    push(1'b0, 12, "R5"); push(1'b1, 20, "R3"); push(1'b0, 12, "R5");
    go(); drain();

    // R1 R3: psc 3, d 5
    setup(3, 1, 2, 1'b0, 1'b0);
    push(1'b0, 28, "R1"); push(1'b1, 24, "R1"); push(1'b0, 28, "R3");
    go(); drain();

    // R4: fixed offset 6
    setup(0, 0, 0, 1'b1, 1'b0);
    push(1'b0, 6, "R4"); push(1'b1, 6, "R4"); push(1'b0, 6, "R4");
    go(); drain();
    setup(3, 1, 2, 1'b1, 1'b0);
    push(1'b0, 32, "R4"); push(1'b1, 28, "R4");
    go(); drain();

    // R6: inputs changed while enabled are ignored
    setup(0, 3, 2, 1'b0, 1'b0);
    push(1'b0, 9, "R6"); push(1'b1, 10, "R6");
    push(1'b0, 9, "R6"); push(1'b1, 10, "R6");
    go();
    repeat (3) @(negedge clk);
    psc = 16'd5; clkl = 16'd40; clkh = 16'd40; off6 = 1'b1;
    drain();

    // R7: disable mid low half, then restart from scratch
    setup(0, 3, 2, 1'b0, 1'b0);
    push(1'b0, 9, "R7");
    go();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(scl_o == 1'b0, "R7", "in low half before disable", scl_o, 0);
    enable = 1'b0;
    @(negedge clk);
    check(scl_o == 1'b1, "R7", "scl high after disable", scl_o, 1);
    check(scl_rise == 1'b0, "R7", "no strobe on disable", scl_rise, 0);
    repeat (20) @(negedge clk);
    check(scl_o == 1'b1, "R7", "scl still high", scl_o, 1);
    push(1'b0, 9, "R7"); push(1'b1, 10, "R7");
    go(); drain();

    // R9: stretching adds one cycle per held cycle at psc 0
    setup(0, 2, 1, 1'b0, 1'b1);
    push(1'b0, 8, "R9"); push(1'b1, 9, "R9");
    push(1'b0, 13, "R9"); push(1'b1, 9, "R9");
    go();
    do @(negedge clk); while (!scl_rise);
    hold = 1'b1;
    repeat (5) @(negedge clk);
    hold = 1'b0;
    drain();

    // R9: same stimulus, stretching off has no effect
    setup(0, 2, 1, 1'b0, 1'b0);
    push(1'b0, 8, "R9"); push(1'b1, 9, "R9"); push(1'b0, 8, "R9");
    go();
    do @(negedge clk); while (!scl_rise);
    hold = 1'b1;
    repeat (5) @(negedge clk);
    hold = 1'b0;
    drain();

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R2", "expectations left", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected done (pending %0d)",
               q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule